// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

The arbiter picks one exception to service from a vector of flags that are already pending and enabled. Each configurable exception has an 8-bit priority byte. A 3-bit grouping setting splits that byte into a group priority in the upper bits and a sub-priority in the lower bits. Three fixed exceptions sit in a tier above every programmable level: number 1 (reset), number 2 (non-maskable) and number 3 (hard fault).

System exceptions 4 to 15 take their bytes from three packed 32-bit handler-priority words. External lines, numbered from 16 upward, take theirs from one packed vector. The result is registered once. One clock after the inputs settle, the block presents the winning exception number, a valid flag and the winner's group priority. An exception-entry stage downstream uses the group priority to decide preemption.

Top module: `grouped_irq_arbiter`

## Requirements
- R1: Among pending configurable exceptions, the one with the numerically smallest priority byte wins.
- R2: Exception 1 beats exception 2, exception 2 beats exception 3, and exception 3 beats every configurable exception, even one whose byte is 0.
- R3: System exception 4+k takes its byte from bits [8*(k%4)+7 : 8*(k%4)] of word k/4. Word 0 is `sys_prio_0`, word 1 is `sys_prio_1` and word 2 is `sys_prio_2`. For example, exception 4 uses `sys_prio_0[7:0]`, exception 11 uses `sys_prio_1[31:24]` and exception 15 uses `sys_prio_2[31:24]`.
- R4: External exception 16+i takes its byte from `ext_prio[8*i+7 : 8*i]`.
- R5: When two candidates have the same group part, the one with the smaller sub-priority part wins.
- R6: When two candidates have identical priority bytes, the lower exception number wins.
- R7: With grouping value G, `win_grp` holds the byte shifted right by G+1, zero-extended; G=7 gives 0. For the fixed tier, `win_grp` holds -3, -2 or -1 as 9-bit two's complement (0x1FD, 0x1FE, 0x1FF) for exceptions 1, 2 and 3.
- R8: When no candidate is pending, `win_valid` is 0 and both `win_num` and `win_grp` read 0.
- R9: Bit 0 of `pend_en` (exception number 0) is ignored and never produces a winner.
- R10: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge, and an active-low reset clears them to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_en | input | NUM_SRC (24) | Pending-and-enabled flag, indexed by exception number |
| grouping | input | 3 | Group/sub-priority split point G |
| sys_prio_0 | input | 32 | Priority bytes of exceptions 4 to 7 |
| sys_prio_1 | input | 32 | Priority bytes of exceptions 8 to 11 |
| sys_prio_2 | input | 32 | Priority bytes of exceptions 12 to 15 |
| ext_prio | input | 8*NUM_EXT (64) | Priority bytes of external exceptions 16 upward |
| win_valid | output | 1 | A winner exists |
| win_num | output | NUM_W (5) | Winning exception number |
| win_grp | output | 9 | Group priority of the winner, signed |

## Verification
Every result is due exactly one rising edge after the inputs are applied, because a single register stage sits between the selection logic and the ports. Each scenario task changes the inputs on a falling edge, waits for the next rising edge and samples 2 ns later. At that point the new value must be present.

The latency check changes the inputs and samples before any rising edge. The previous winner must still be held, which confirms that nothing reaches the ports combinationally.

// File: rtl/grouped_irq_arbiter.sv
module grouped_irq_arbiter #(
  parameter  int NUM_EXT = 8,
  localparam int NUM_SRC = 16 + NUM_EXT,
  localparam int NUM_W   = $clog2(NUM_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_SRC-1:0]      pend_en,
  input  logic [2:0]              grouping,
  input  logic [31:0]             sys_prio_0,
  input  logic [31:0]             sys_prio_1,
  input  logic [31:0]             sys_prio_2,
  input  logic [8*NUM_EXT-1:0]    ext_prio,
  output logic                    win_valid,
  output logic [NUM_W-1:0]        win_num,
  output logic signed [8:0]       win_grp
);

  localparam logic [9:0] KEY_NONE = 10'h3FF;

  logic [95:0] sys_flat;
  logic [9:0]  key_a [NUM_SRC];

  assign sys_flat = {sys_prio_2, sys_prio_1, sys_prio_0};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_key
    if (i == 0) begin : g_none
      assign key_a[i] = KEY_NONE;
    end else if (i < 4) begin : g_fixed
      assign key_a[i] = 10'(i - 1);
    end else if (i < 16) begin : g_sys
      assign key_a[i] = {2'b00, sys_flat[8*(i-4) +: 8]} + 10'd3;
    end else begin : g_ext
      assign key_a[i] = {2'b00, ext_prio[8*(i-16) +: 8]} + 10'd3;
    end
  end

  logic [9:0]       best_key;
  logic [NUM_W-1:0] best_idx;
  logic             found;

  always_comb begin
    best_key = KEY_NONE;
    best_idx = '0;
    found    = 1'b0;
    for (int i = NUM_SRC - 1; i >= 1; i--) begin
      if (pend_en[i] && key_a[i] <= best_key) begin
        best_key = key_a[i];
        best_idx = NUM_W'(i);
        found    = 1'b1;
      end
    end
  end

  logic [9:0] lvl;
  logic [7:0] win_byte;
  logic [3:0] shamt;
  logic [8:0] grp_nxt;

  assign lvl      = best_key - 10'd3;
  assign win_byte = lvl[7:0];
  assign shamt    = {1'b0, grouping} + 4'd1;
  assign grp_nxt  = !found        ? 9'd0 :
                    best_key < 3  ? lvl[8:0] :
                                    {1'b0, win_byte >> shamt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
      win_num   <= '0;
      win_grp   <= '0;
    end else begin
      win_valid <= found;
      win_num   <= best_idx;
      win_grp   <= grp_nxt;
    end
  end

  logic primed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> (win_num == '0 && win_grp == '0));

  // R10
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> (win_valid == $past(|pend_en[NUM_SRC-1:1])));

  // R2
  reset_tier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(pend_en[1])) |-> (win_num == NUM_W'(1) && win_grp == -9'sd3));

  // R7
  fixed_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_num > NUM_W'(3)) |-> !win_grp[8]);

  // R9
  no_zero_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> win_num != '0);

endmodule

// File: tb/grouped_irq_arbiter_test.sv
module grouped_irq_arbiter_test;
  localparam int NE = 8;
  localparam int NS = 16 + NE;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NS-1:0] pend_en = '0;
  logic [2:0]    grouping = '0;
  logic [31:0]   sys_prio_0 = '1, sys_prio_1 = '1, sys_prio_2 = '1;
  logic [8*NE-1:0] ext_prio = '1;
  logic          win_valid;
  logic [4:0]    win_num;
  logic signed [8:0] win_grp;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  grouped_irq_arbiter #(.NUM_EXT(NE)) uut (
    .clk(clk), .rst_n(rst_n), .pend_en(pend_en), .grouping(grouping),
    .sys_prio_0(sys_prio_0), .sys_prio_1(sys_prio_1), .sys_prio_2(sys_prio_2),
    .ext_prio(ext_prio), .win_valid(win_valid), .win_num(win_num), .win_grp(win_grp)
  );

  task automatic check(string req, logic ev, logic [4:0] en, logic [8:0] eg);
    tests++;
    if (win_valid !== ev || win_num !== en || win_grp !== eg) begin
      fails++;
      $display("FAIL %s: got v=%0b n=%0d g=%h, expected v=%0b n=%0d g=%h",
               req, win_valid, win_num, win_grp, ev, en, eg);
    end
  endtask

  task automatic apply(logic [NS-1:0] p, logic [2:0] g);
    @(negedge clk);
    pend_en = p;
    grouping = g;
    @(posedge clk);
    #2;
  endtask

  task automatic set_ext(int i, logic [7:0] b);
    ext_prio[8*i +: 8] = b;
  endtask

  task automatic t_reset;
    check("R10 reset", 0, 0, 0);
  endtask

  task automatic t_idle;
    apply('0, 3'd0);
    check("R8 idle", 0, 0, 0);
  endtask

  task automatic t_byte_order;
    set_ext(0, 8'h80);
    set_ext(1, 8'h40);
    apply(NS'(3) << 16, 3'd0);
    check("R1 lower byte", 1, 17, 9'h020);
  endtask

  task automatic t_sys_pack;
    sys_prio_0 = 32'hFFFF_FF06;
    apply(NS'(3) << 4, 3'd0);
    check("R3 exc4 slot", 1, 4, 9'h003);
    sys_prio_0 = 32'hFFFF_FFFF;
    sys_prio_1 = 32'h10FF_FFFF;
    apply(NS'(16'hFFF0), 3'd0);
    check("R3 exc11 slot", 1, 11, 9'h008);
    sys_prio_1 = '1;
    sys_prio_2 = 32'h02FF_FFFF;
    apply(NS'(16'hFFF0), 3'd0);
    check("R3 exc15 slot", 1, 15, 9'h001);
    sys_prio_2 = '1;
  endtask

  task automatic t_ext_pack;
    for (int i = 0; i < NE; i++) set_ext(i, 8'h50);
    set_ext(7, 8'h01);
    apply({NE{1'b1}} << 16, 3'd0);
    check("R4 ext slot", 1, 23, 9'h000);
  endtask

  task automatic t_fixed;
    set_ext(0, 8'h00);
    apply(NS'(32'h1_000E), 3'd0);
    check("R2 reset first", 1, 1, 9'h1FD);
    apply(NS'(32'h1_000C), 3'd0);
    check("R2 nmi second", 1, 2, 9'h1FE);
    apply(NS'(32'h1_0008), 3'd0);
    check("R2 fault over byte0", 1, 3, 9'h1FF);
  endtask

  task automatic t_sub;
    set_ext(0, 8'h25);
    set_ext(1, 8'h23);
    apply(NS'(3) << 16, 3'd3);
    check("R5 sub-priority", 1, 17, 9'h002);
  endtask

  task automatic t_tie;
    set_ext(2, 8'h40);
    set_ext(4, 8'h40);
    apply(NS'(5) << 18, 3'd0);
    check("R6 number tie ext", 1, 18, 9'h020);
    sys_prio_0 = 32'hFF40_FFFF;
    set_ext(0, 8'h40);
    apply((NS'(1) << 16) | (NS'(1) << 6), 3'd0);
    check("R6 number tie sys", 1, 6, 9'h020);
    sys_prio_0 = '1;
  endtask

  task automatic t_group;
    set_ext(0, 8'hF0);
    apply(NS'(1) << 16, 3'd7);
    check("R7 grouping 7", 1, 16, 9'h000);
    apply(NS'(1) << 16, 3'd2);
    check("R7 grouping 2", 1, 16, 9'h01E);
  endtask

  task automatic t_bit0;
    apply(NS'(1), 3'd0);
    check("R9 bit0 ignored", 0, 0, 0);
  endtask

  task automatic t_latency;
    set_ext(3, 8'h10);
    apply(NS'(1) << 19, 3'd0);
    check("R10 after edge", 1, 19, 9'h008);
    @(negedge clk);
    pend_en = NS'(1) << 2;
    #2;
    check("R10 held before edge", 1, 19, 9'h008);
    @(posedge clk);
    #2;
    check("R10 next edge", 1, 2, 9'h1FE);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset;
    rst_n = 1;
    t_idle;
    t_byte_order;
    t_sys_pack;
    t_ext_pack;
    t_fixed;
    t_sub;
    t_tie;
    t_group;
    t_bit0;
    t_latency;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule